// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block steers eight level-sensitive shared interrupt request lines (named A through H) and one power-management interrupt (the SCI) onto the request inputs of two interrupt controllers: a 16-input legacy controller and a 24-input advanced controller. Each output level is the OR of every source currently routed to it. No edges are formed and no priority is applied. Each output is a continuous level that the controllers sample themselves.

On the legacy side, every request line has a routing byte. The byte names a legacy input and carries a disable bit, so several lines may share one input. On the advanced side, the mapping is fixed: line n drives input 16+n, so no two lines share an input. The SCI can be merged onto input 9, 10, 11, 20 or 21, chosen by an encoded select byte. The SCI level is held in a register, and outputs reflect it from the next clock edge.

A byte-wide configuration port writes and reads the eight routing bytes and the SCI select byte. A one-cycle pulse reports every routing-byte write, so that consumers can re-evaluate cached routes.

Top module: `irq_route_top`

## Requirements
- R1: After reset, every routing byte reads 0x80, the SCI select byte reads 0x00, the stored SCI level is 0, and route_chg_o is 0.
- R2: Configuration address 0..3 holds the routing bytes of lines A..D, address 4..7 holds those of lines E..H, and address 8 holds the SCI select byte. The full byte written is read back combinationally on cfg_rdata_o. Addresses 9..15 read 0x00, and writes to them change no stored byte.
- R3: pic_irq_o[k] is high when any line p has pirq_i[p] high and its routing byte has bit 7 = 0 and bits 4:0 = k. The output follows pirq_i without a clock.
- R4: A routing byte with bit 7 = 1 removes its line from every legacy output.
- R5: A routing byte with bit 7 = 0 and bits 4:0 in 16..31 routes its line to no legacy output.
- R6: apic_irq_o[16+n] is high whenever pirq_i[n] is high, whatever the routing bytes hold.
- R7: SCI select bits 2:0 choose the SCI target: 0 = input 9, 1 = input 10, 2 = input 11, 4 = input 20, 5 = input 21. Codes 3, 6 and 7 leave the SCI unrouted. The SCI drives the chosen advanced input and, for targets below 16, the same-numbered legacy input, ORed with any line routed there.
- R8: The SCI level is sampled on each rising clock edge, and outputs show the value sampled at the last edge.
- R9: Advanced inputs 0..15 other than the selected SCI target are always low.
- R10: route_chg_o is high for exactly the cycle after a write to address 0..7. A write to any other address does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pirq_i | input | 8 | Shared request lines, bit n is line n (A = 0) |
| sci_i | input | 1 | SCI level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for cfg_addr_i |
| pic_irq_o | output | 16 | Legacy controller request levels |
| apic_irq_o | output | 24 | Advanced controller request levels |
| route_chg_o | output | 1 | Routing-changed pulse |

## Verification
The hardest cases to reach are the merge points. These are an SCI and one or more enabled lines landing on the same legacy input, and an SCI at target 20 or 21 landing on top of the fixed mapping of lines E or F. Each needs a particular select code, a particular set of routing bytes and a particular input pattern all at once. Directed steps build these overlaps on purpose. Seeded random writes then mix IRQ numbers from the whole 5-bit range with random disable bits and select codes, including reserved ones, while the inputs toggle every cycle. A bench model that tracks the sampled SCI level predicts both output vectors.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned N_PIRQ  = 8;
  localparam int unsigned N_PIC   = 16;
  localparam int unsigned N_APIC  = N_PIC + N_PIRQ;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned IRQ_W   = 5;
  localparam int unsigned DIS_BIT = DATA_W - 1;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned IDX_W   = $clog2(N_PIRQ);

  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(N_PIRQ);
  localparam logic [DATA_W-1:0] ROUT_RST = 8'h80;
  localparam logic [DATA_W-1:0] SEL_RST  = 8'h00;

  // one-hot SCI target over the advanced inputs, zero for reserved codes
  function automatic logic [N_APIC-1:0] sci_target(input logic [SEL_W-1:0] sel);
    logic [N_APIC-1:0] v;
    v = '0;
    case (sel)
      3'd0: v[9]  = 1'b1;
      3'd1: v[10] = 1'b1;
      3'd2: v[11] = 1'b1;
      3'd4: v[20] = 1'b1;
      3'd5: v[21] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
  import irq_route_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [N_PIRQ-1:0][DATA_W-1:0] rt_o,
  output logic [DATA_W-1:0]             sel_o,
  output logic                          chg_o
);
  logic [N_PIRQ-1:0][DATA_W-1:0] rt_q;
  logic [DATA_W-1:0]             sel_q;
  logic                          chg_q;
  logic                          rt_hit;

  assign rt_hit = addr_i < SEL_ADDR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < N_PIRQ; p++) rt_q[p] <= ROUT_RST;
      sel_q <= SEL_RST;
      chg_q <= 1'b0;
    end else begin
      chg_q <= we_i && rt_hit;
      if (we_i && rt_hit)             rt_q[addr_i[IDX_W-1:0]] <= wdata_i;
      else if (we_i && addr_i == SEL_ADDR) sel_q <= wdata_i;
    end
  end

  always_comb begin
    if (rt_hit)                rdata_o = rt_q[addr_i[IDX_W-1:0]];
    else if (addr_i == SEL_ADDR) rdata_o = sel_q;
    else                       rdata_o = '0;
  end

  assign rt_o  = rt_q;
  assign sel_o = sel_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/irq_route_pic.sv
module irq_route_pic
  import irq_route_pkg::*;
(
  input  logic [N_PIRQ-1:0]             pirq_i,
  input  logic [N_PIRQ-1:0][DATA_W-1:0] rt_i,
  input  logic                          sci_i,
  input  logic [N_PIC-1:0]              sci_tgt_i,
  output logic [N_PIC-1:0]              pic_o
);
  for (genvar k = 0; k < N_PIC; k++) begin : g_line
    logic hit;
    always_comb begin
      hit = sci_i & sci_tgt_i[k];
      for (int p = 0; p < N_PIRQ; p++) begin
        // 5-bit compare: numbers 16..31 never match a legacy line
        if (!rt_i[p][DIS_BIT] && rt_i[p][IRQ_W-1:0] == IRQ_W'(k) && pirq_i[p])
          hit = 1'b1;
      end
    end
    assign pic_o[k] = hit;
  end
endmodule

// File: rtl/irq_route_apic.sv
module irq_route_apic
  import irq_route_pkg::*;
(
  input  logic [N_PIRQ-1:0] pirq_i,
  input  logic              sci_i,
  input  logic [N_APIC-1:0] sci_tgt_i,
  output logic [N_APIC-1:0] apic_o
);
  for (genvar g = 0; g < N_APIC; g++) begin : g_gsi
    if (g >= N_PIC) begin : g_shared
      assign apic_o[g] = pirq_i[g-N_PIC] | (sci_i & sci_tgt_i[g]);
    end else begin : g_low
      assign apic_o[g] = sci_i & sci_tgt_i[g];
    end
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PIRQ-1:0] pirq_i,
  input  logic              sci_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic [N_PIC-1:0]  pic_irq_o,
  output logic [N_APIC-1:0] apic_irq_o,
  output logic              route_chg_o
);
  logic [N_PIRQ-1:0][DATA_W-1:0] rt;
  logic [DATA_W-1:0]             sci_sel;
  logic [N_APIC-1:0]             sci_tgt;
  logic                          sci_q;

  // stored SCI level; equal levels leave it untouched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sci_q <= 1'b0;
    else if (sci_i != sci_q) sci_q <= sci_i;
  end

  assign sci_tgt = sci_target(sci_sel[SEL_W-1:0]);

  irq_route_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .rt_o    (rt),
    .sel_o   (sci_sel),
    .chg_o   (route_chg_o)
  );

  irq_route_pic u_pic (
    .pirq_i    (pirq_i),
    .rt_i      (rt),
    .sci_i     (sci_q),
    .sci_tgt_i (sci_tgt[N_PIC-1:0]),
    .pic_o     (pic_irq_o)
  );

  irq_route_apic u_apic (
    .pirq_i    (pirq_i),
    .sci_i     (sci_q),
    .sci_tgt_i (sci_tgt),
    .apic_o    (apic_irq_o)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [N_PIRQ-1:0]             pirq_i,
  input logic                          cfg_we_i,
  input logic [ADDR_W-1:0]             cfg_addr_i,
  input logic [N_PIC-1:0]              pic_irq_o,
  input logic [N_APIC-1:0]             apic_irq_o,
  input logic                          route_chg_o,
  input logic [DATA_W-1:0]             sel_i,
  input logic [N_PIRQ-1:0][DATA_W-1:0] rt_i
);
  logic all_dis, sel_rsv, rt_wr;

  always_comb begin
    all_dis = 1'b1;
    for (int p = 0; p < N_PIRQ; p++) all_dis &= rt_i[p][DIS_BIT];
  end
  assign sel_rsv = sel_i[2:0] == 3'd3 || sel_i[2:0] == 3'd6 || sel_i[2:0] == 3'd7;
  assign rt_wr   = cfg_we_i && cfg_addr_i < SEL_ADDR;

  // R10
  chg_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_wr |=> route_chg_o);
  // R10
  chg_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rt_wr |=> !route_chg_o);
  // R6
  pirq_apic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apic_irq_o[N_APIC-1:N_PIC] & pirq_i) == pirq_i);
  // R9
  low_gsi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apic_irq_o[8:0] == '0 && apic_irq_o[15:12] == '0);
  // R4
  all_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_dis |-> (pic_irq_o[8:0] == '0 && pic_irq_o[15:12] == '0));
  // R7
  sci_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_dis && sel_rsv) |-> (pic_irq_o == '0 && apic_irq_o[N_PIC-1:0] == '0));
endmodule

bind irq_route_top irq_route_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pirq_i      (pirq_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .pic_irq_o   (pic_irq_o),
  .apic_irq_o  (apic_irq_o),
  .route_chg_o (route_chg_o),
  .sel_i       (sci_sel),
  .rt_i        (rt)
);

// File: tb/irq_route_top_tb.sv
`timescale 1ns/1ps
module irq_route_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pirq = '0;
  logic        sci = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pic;
  logic [23:0] apic;
  logic        chg;

  int total = 0, fails = 0;
  logic [7:0] m_rt [8];
  logic [7:0] m_sel;
  logic       sci_m;

  always #2.5 clk = ~clk;

  irq_route_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pirq_i(pirq), .sci_i(sci),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .pic_irq_o(pic), .apic_irq_o(apic), .route_chg_o(chg)
  );

  // R8: bench view of the sampled SCI level
  always @(posedge clk or negedge rst_n)
    if (!rst_n) sci_m <= 1'b0; else sci_m <= sci;

  function automatic int sci_gsi();
    case (m_sel[2:0])
      3'd0: return 9;  3'd1: return 10; 3'd2: return 11;
      3'd4: return 20; 3'd5: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] exp_pic();
    logic [15:0] v = '0;
    int g = sci_gsi();
    for (int p = 0; p < 8; p++)
      if (!m_rt[p][7] && m_rt[p][4:0] < 5'd16 && pirq[p]) v[m_rt[p][3:0]] = 1'b1;
    if (g >= 0 && g < 16 && sci_m) v[g] = 1'b1;
    return v;
  endfunction

  function automatic logic [23:0] exp_apic();
    logic [23:0] v = '0;
    int g = sci_gsi();
    for (int n = 0; n < 8; n++) v[16+n] = pirq[n];
    if (g >= 0 && sci_m) v[g] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic out_check(input string tag);
    #1;
    check({tag, " pic"}, 32'(pic), 32'(exp_pic()));
    check({tag, " apic"}, 32'(apic), 32'(exp_apic()));
  endtask

  task automatic rd_check(input logic [3:0] a, input string tag);
    logic [7:0] e;
    addr = a;
    #1;
    e = (a < 4'd8) ? m_rt[a[2:0]] : (a == 4'd8) ? m_sel : 8'h00;
    check(tag, 32'(rdata), 32'(e));
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a < 4'd8) m_rt[a[2:0]] = d;
    else if (a == 4'd8) m_sel = d;
    #1;
    check("R10 route_chg after write", 32'(chg), 32'(a < 4'd8));
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int p = 0; p < 8; p++) m_rt[p] = 8'h80;
    m_sel = 8'h00;
    void'($urandom(32'h1234_abcd));
    repeat (3) @(negedge clk);
    #1;
    check("R1 outputs in reset pic", 32'(pic), 32'h0);
    check("R1 route_chg in reset", 32'(chg), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 16; a++) rd_check(4'(a), "R1 R2 reset readback");
    #1 check("R1 route_chg after reset", 32'(chg), 32'h0);

    // R4: all lines disabled, advanced side still follows (R6)
    @(negedge clk); pirq = 8'hFF; out_check("R4 R6 all disabled");
    // R3: two lines share legacy input 5
    pirq = 8'h00;
    do_write(4'd0, 8'h05); do_write(4'd1, 8'h05);
    @(negedge clk); pirq = 8'h02; out_check("R3 shared line B");
    @(negedge clk); pirq = 8'h03; out_check("R3 shared both");
    // R4: single disable bit
    do_write(4'd2, 8'h85);
    @(negedge clk); pirq = 8'h04; out_check("R4 disabled line C");
    // R5: numbers 16 and 31
    do_write(4'd3, 8'h10); do_write(4'd4, 8'h1F);
    @(negedge clk); pirq = 8'h18; out_check("R5 high irq numbers");
    // R2: unmapped address write ignored
    do_write(4'd9, 8'h55);
    for (int a = 0; a < 16; a++) rd_check(4'(a), "R2 readback after unmapped write");
    // R2 group E-H
    do_write(4'd7, 8'h0C); rd_check(4'd7, "R2 line H byte");
    @(negedge clk); pirq = 8'h80; out_check("R3 line H to 12");

    // R7 R8: every select code, SCI merged with line on 9 and on E (gsi 20)
    do_write(4'd5, 8'h09);
    for (int c = 0; c < 8; c++) begin
      do_write(4'd8, 8'(c));
      @(negedge clk); sci = 1'b1; pirq = 8'h20;
      out_check("R8 sci not yet sampled");
      @(negedge clk); out_check("R7 R9 sci routed");
      @(negedge clk); sci = 1'b0; pirq = 8'h10;
      out_check("R8 sci held one cycle");
      @(negedge clk); out_check("R7 sci released");
    end

    // random phase
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        do_write(4'($urandom_range(0, 10)), 8'($urandom));
      end else begin
        @(negedge clk);
        pirq = 8'($urandom);
        sci = 1'($urandom);
        out_check("R3 R5 R6 R7 random");
      end
    end
    for (int a = 0; a < 16; a++) rd_check(4'(a), "R2 final readback");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule